// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the effective address for a 64-bit load/store datapath. Each request carries a base value, an index value, a two-bit scale code, a signed 32-bit displacement, and two flags that mark the base or the index as absent. The block adds the sign-extended displacement, the base, and the index shifted left by the scale code. The sum wraps modulo 2^64. The result is registered, so it appears one clock after the request is accepted.

A request either issues a memory access or runs in value mode. In value mode the block returns the computed sum as a data result for pointer or arithmetic use, and it raises no memory request. For memory accesses the block also takes an access size code and flags an address that is not a multiple of that size.

The output stage is a small state machine with three named states:
- `ST_IDLE`: nothing is presented.
- `ST_MEM`: a memory request is presented.
- `ST_VALUE`: a value result is presented.

The state taken at each rising edge depends only on the inputs sampled at that edge:
- With no request, the next state is `ST_IDLE`.
- A request with value mode clear goes to `ST_MEM`.
- A request with value mode set goes to `ST_VALUE`.

These transitions apply from any state, so back-to-back requests move directly between `ST_MEM` and `ST_VALUE`.

Top module: `addr_gen_unit`

## Requirements
- R1: `ea_out` equals displacement + base term + scaled index term, computed modulo 2^64 (carries out of bit 63 are dropped).
- R2: Scale code k (0..3) multiplies the index by 2^k, that is by 1, 2, 4 or 8.
- R3: When `base_absent` is 1, the base contributes zero, whatever the value of `base_in`.
- R4: When `index_absent` is 1, the index contributes zero, whatever the values of `index_in` and `scale_code`.
- R5: `disp_in` is a two's-complement 32-bit value and is sign-extended to 64 bits before the add.
- R6: A request sampled with `req_valid` high at a rising edge drives `rsp_valid` high from that edge until the next one. A cycle with `req_valid` low drives `rsp_valid` low after the edge.
- R7: A response to a request with `value_mode` clear asserts `mem_req` and not `value_rdy`. A response to a request with `value_mode` set asserts `value_rdy` and not `mem_req`. The two are never high together.
- R8: Access size code s (0..3) means 2^s bytes. For a memory request, `misaligned` is 1 exactly when the low s bits of `ea_out` are not all zero. For a value-mode response, `misaligned` is 0.
- R9: After reset, and until the first request, `rsp_valid`, `mem_req`, `value_rdy` and `misaligned` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| base_in | input | 64 | Base register value |
| base_absent | input | 1 | Base omitted; contributes zero |
| index_in | input | 64 | Index register value |
| index_absent | input | 1 | Index omitted; contributes zero |
| scale_code | input | 2 | Index left-shift amount, 0 to 3 |
| disp_in | input | 32 | Signed displacement |
| size_code | input | 2 | Access size as log2 of bytes |
| value_mode | input | 1 | Return the sum as a value; no memory request |
| rsp_valid | output | 1 | Registered response present |
| mem_req | output | 1 | Response is a memory request |
| value_rdy | output | 1 | Response is a value result |
| ea_out | output | 64 | Registered effective address or value |
| misaligned | output | 1 | Memory address not a multiple of the access size |

## Verification
All results (`ea_out`, `misaligned`, `rsp_valid`, `mem_req` and `value_rdy`) are due one rising edge after the request is sampled. The bench drives each request on a falling edge and reads the outputs at the following falling edge, half a period after the capturing edge. For latency, `rsp_valid` is also read just after the inputs are driven but before the edge, where it must still reflect the earlier idle cycle. A later idle cycle then shows `rsp_valid` dropping after exactly one edge. Back-to-back requests alternate between the two modes, so the direct moves between `ST_MEM` and `ST_VALUE` are checked cycle by cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int ADDR_W  = 64;
    localparam int DISP_W  = 32;
    localparam int SCALE_W = 2;
    localparam int SIZE_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MEM   = 2'd1,
        ST_VALUE = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/agu_operand_sel.sv
module agu_operand_sel #(
    parameter int ADDR_W  = 64,
    parameter int DISP_W  = 32,
    parameter int SCALE_W = 2
) (
    input  logic [ADDR_W-1:0]  base_in,
    input  logic               base_absent,
    input  logic [ADDR_W-1:0]  index_in,
    input  logic               index_absent,
    input  logic [SCALE_W-1:0] scale_code,
    input  logic [DISP_W-1:0]  disp_in,
    output logic [ADDR_W-1:0]  base_term,
    output logic [ADDR_W-1:0]  index_term,
    output logic [ADDR_W-1:0]  disp_term
);
    localparam int N_SCALE = 1 << SCALE_W;
    localparam int EXT_W   = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] index_masked;
    logic [ADDR_W-1:0] shifted [N_SCALE];

    assign index_masked = index_absent ? '0 : index_in;

    // One pre-shifted copy of the index per scale code.
    for (genvar g = 0; g < N_SCALE; g++) begin : g_scale
        assign shifted[g] = index_masked << g;
    end

    assign base_term  = base_absent ? '0 : base_in;
    assign index_term = shifted[scale_code];
    assign disp_term  = {{EXT_W{disp_in[DISP_W-1]}}, disp_in};

    // R4: an absent index must contribute nothing at any scale.
    always_comb begin
        if (index_absent) begin
            p_index_zero_r4: assert (index_term == '0)
                else $error("absent index produced a nonzero term");
        end
    end

endmodule

// File: rtl/agu_align_chk.sv
module agu_align_chk #(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size_code,
    output logic              unaligned
);
    localparam int LOW_W = (1 << SIZE_W) - 1;

    logic [LOW_W-1:0] low_mask;

    always_comb begin
        for (int i = 0; i < LOW_W; i++) begin
            low_mask[i] = (i < int'(size_code));
        end
        unaligned = |(addr[LOW_W-1:0] & low_mask);
    end

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
    import agu_pkg::*;
#(
    parameter int P_ADDR_W  = ADDR_W,
    parameter int P_DISP_W  = DISP_W,
    parameter int P_SCALE_W = SCALE_W,
    parameter int P_SIZE_W  = SIZE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [P_ADDR_W-1:0]  base_in,
    input  logic                 base_absent,
    input  logic [P_ADDR_W-1:0]  index_in,
    input  logic                 index_absent,
    input  logic [P_SCALE_W-1:0] scale_code,
    input  logic [P_DISP_W-1:0]  disp_in,
    input  logic [P_SIZE_W-1:0]  size_code,
    input  logic                 value_mode,
    output logic                 rsp_valid,
    output logic                 mem_req,
    output logic                 value_rdy,
    output logic [P_ADDR_W-1:0]  ea_out,
    output logic                 misaligned
);
    logic [P_ADDR_W-1:0] base_term, index_term, disp_term;
    logic [P_ADDR_W-1:0] ea_sum;
    logic                unaligned_c;
    rsp_state_e          state_q, state_d;
    logic                mis_q;

    agu_operand_sel #(
        .ADDR_W  (P_ADDR_W),
        .DISP_W  (P_DISP_W),
        .SCALE_W (P_SCALE_W)
    ) u_opsel (
        .base_in      (base_in),
        .base_absent  (base_absent),
        .index_in     (index_in),
        .index_absent (index_absent),
        .scale_code   (scale_code),
        .disp_in      (disp_in),
        .base_term    (base_term),
        .index_term   (index_term),
        .disp_term    (disp_term)
    );

    // Three-way sum; wraps modulo 2^P_ADDR_W.
    assign ea_sum = disp_term + base_term + index_term;

    agu_align_chk #(
        .ADDR_W (P_ADDR_W),
        .SIZE_W (P_SIZE_W)
    ) u_align (
        .addr      (ea_sum),
        .size_code (size_code),
        .unaligned (unaligned_c)
    );

    // Next-state selection.
    always_comb begin
        unique case ({req_valid, value_mode})
            2'b10:   state_d = ST_MEM;
            2'b11:   state_d = ST_VALUE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ea_out  <= '0;
            mis_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                ea_out <= ea_sum;
                mis_q  <= unaligned_c && !value_mode;
            end
        end
    end

    // Output decode from state.
    always_comb begin
        rsp_valid  = 1'b0;
        mem_req    = 1'b0;
        value_rdy  = 1'b0;
        misaligned = 1'b0;
        unique case (state_q)
            ST_MEM: begin
                rsp_valid  = 1'b1;
                mem_req    = 1'b1;
                misaligned = mis_q;
            end
            ST_VALUE: begin
                rsp_valid = 1'b1;
                value_rdy = 1'b1;
            end
            default: ;
        endcase
    end

    // R7: a response is one kind only.
    p_one_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, value_rdy}));

    // R6: every accepted request answers one edge later.
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R6: an idle cycle gives no response one edge later.
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R7: value-mode requests never issue memory traffic.
    p_value_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && value_mode) |=> (value_rdy && !mem_req));

    // R8: value results never flag misalignment.
    p_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        value_rdy |-> !misaligned);

endmodule

// File: tb/addr_gen_unit_tb.sv
module addr_gen_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] base_in = '0;
    logic        base_absent = 1'b0;
    logic [63:0] index_in = '0;
    logic        index_absent = 1'b0;
    logic [1:0]  scale_code = '0;
    logic [31:0] disp_in = '0;
    logic [1:0]  size_code = '0;
    logic        value_mode = 1'b0;
    logic        rsp_valid, mem_req, value_rdy, misaligned;
    logic [63:0] ea_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    addr_gen_unit u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .base_in      (base_in),
        .base_absent  (base_absent),
        .index_in     (index_in),
        .index_absent (index_absent),
        .scale_code   (scale_code),
        .disp_in      (disp_in),
        .size_code    (size_code),
        .value_mode   (value_mode),
        .rsp_valid    (rsp_valid),
        .mem_req      (mem_req),
        .value_rdy    (value_rdy),
        .ea_out       (ea_out),
        .misaligned   (misaligned)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%h expected 0x%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model(logic [63:0] b, logic bn, logic [63:0] ix,
                                          logic inn, logic [1:0] sc, logic [31:0] d);
        logic signed [31:0] ds;
        logic signed [63:0] dext;
        logic [63:0] bt, it;
        ds   = $signed(d);
        dext = ds;
        bt   = bn ? 64'd0 : b;
        it   = inn ? 64'd0 : ix * (64'd1 << sc);
        return 64'(dext) + bt + it;
    endfunction

    // Drive one request at a falling edge, read results at the next falling edge.
    task automatic issue(string req, logic [63:0] b, logic bn, logic [63:0] ix, logic inn,
                         logic [1:0] sc, logic [31:0] d, logic [1:0] sz, logic vm);
        logic [63:0] exp;
        logic        exp_mis;
        base_in = b; base_absent = bn; index_in = ix; index_absent = inn;
        scale_code = sc; disp_in = d; size_code = sz; value_mode = vm;
        req_valid = 1'b1;
        exp = model(b, bn, ix, inn, sc, d);
        exp_mis = !vm && ((exp & ((64'd1 << sz) - 64'd1)) != 64'd0);
        @(negedge clk);
        chk(req, "ea_out", ea_out, exp);
        chk("R7", "mem_req", {63'd0, mem_req}, {63'd0, !vm});
        chk("R7", "value_rdy", {63'd0, value_rdy}, {63'd0, vm});
        chk("R8", "misaligned", {63'd0, misaligned}, {63'd0, exp_mis});
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R9", "rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R9", "mem_req", {63'd0, mem_req}, 64'd0);
        chk("R9", "value_rdy", {63'd0, value_rdy}, 64'd0);
        chk("R9", "misaligned", {63'd0, misaligned}, 64'd0);
    endtask

    task automatic t_examples;
        issue("R2", 64'hf000, 0, 64'h0100, 0, 2'd2, 32'd0, 2'd0, 0);      // 0xf400
        issue("R4", 64'hf000, 0, 64'hdead_beef, 1, 2'd3, 32'd8, 2'd0, 0); // 0xf008
        issue("R3", 64'h1234_5678, 1, 64'hf000, 0, 2'd1, 32'h80, 2'd0, 0); // 0x1e080
        chk("R3", "ea_out literal", ea_out, 64'h1e080);
    endtask

    task automatic t_scales;
        for (int k = 0; k < 4; k++) begin
            issue("R2", 64'h1000, 0, 64'h0000_0000_0000_0013, 0, 2'(k), 32'd4, 2'd0, 0);
        end
    endtask

    task automatic t_disp_wrap;
        issue("R5", 64'h1_0000, 0, 64'd0, 1, 2'd0, 32'hffff_fff0, 2'd0, 0);
        chk("R5", "negative disp literal", ea_out, 64'hfff0);
        issue("R1", 64'hffff_ffff_ffff_fff0, 0, 64'h10, 0, 2'd3, 32'h7fff_ffff, 2'd0, 0);
        issue("R1", 64'h8000_0000_0000_0000, 0, 64'h8000_0000_0000_0000, 0, 2'd0, 32'd0, 2'd0, 0);
        chk("R1", "wrap to zero", ea_out, 64'd0);
    endtask

    task automatic t_align;
        issue("R8", 64'h1002, 0, 64'd0, 1, 2'd0, 32'd0, 2'd1, 0); // aligned 2
        issue("R8", 64'h1002, 0, 64'd0, 1, 2'd0, 32'd0, 2'd2, 0); // misaligned 4
        chk("R8", "flag for 4-byte at 0x1002", {63'd0, misaligned}, 64'd1);
        issue("R8", 64'h1004, 0, 64'd0, 1, 2'd0, 32'd0, 2'd3, 0); // misaligned 8
        issue("R8", 64'h1007, 0, 64'd0, 1, 2'd0, 32'd0, 2'd0, 0); // byte always fine
        issue("R8", 64'h1007, 0, 64'd0, 1, 2'd0, 32'd0, 2'd3, 1); // value mode: no flag
    endtask

    task automatic t_value_mode;
        issue("R7", 64'h2000, 0, 64'h30, 0, 2'd3, 32'hffff_ffff, 2'd0, 1);
        chk("R7", "rsp_valid", {63'd0, rsp_valid}, 64'd1);
    endtask

    task automatic t_latency;
        @(negedge clk);
        chk("R6", "idle before request", {63'd0, rsp_valid}, 64'd0);
        base_in = 64'h40; base_absent = 0; index_absent = 1; disp_in = 0;
        size_code = 0; value_mode = 0; req_valid = 1'b1;
        #1;
        chk("R6", "no response before edge", {63'd0, rsp_valid}, 64'd0);
        @(negedge clk);
        chk("R6", "response after one edge", {63'd0, rsp_valid}, 64'd1);
        // back-to-back: alternate modes
        value_mode = 1'b1; base_in = 64'h44;
        @(negedge clk);
        chk("R6", "second response", {63'd0, value_rdy}, 64'd1);
        chk("R1", "second value", ea_out, 64'h44);
        value_mode = 1'b0; base_in = 64'h48;
        @(negedge clk);
        chk("R7", "third is memory", {63'd0, mem_req}, 64'd1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R6", "idle after drop", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_examples();
        t_scales();
        t_disp_wrap();
        t_align();
        t_value_mode();
        t_latency();
        finish_run();
    end

endmodule